// File: doc/BRIEF.md
# Serial ADC frame alignment controller

This block sequences the bring-up of a deserialized high-speed ADC link without host involvement. A start request first holds the capture clock generator in reset for a short window, releases it and waits for the lock indication. Word alignment follows: the captured frame nibble is compared with the expected training pattern, and a one-cycle bitslip request is issued on each mismatch, up to a fixed number of attempts.

Once the word is aligned, the block steps the input delay tap upward from zero. At each step it lets the capture path settle and compares the new frame with the one held from the step before. The first change marks an edge of the data eye. The block then programs a tap offset from that edge and reports done. A failed alignment, or a sweep that finds no edge, ends with the error flag set. The lock indication is also passed out, together with the live frame nibble, as a combined status word.

Top module: `frame_align_ctrl`

## Requirements
- R1: After reset, busy, done, err, bitslip and clock-generator reset are all low and the tap output is 0.
- R2: A start request in idle raises the clock-generator reset and busy. The reset is then released. No bitslip pulse and no tap change occur until the lock input is high.
- R3: The frame matches when all four bits equal 4'b1100. If the frame matches at its first check, no bitslip pulse is issued.
- R4: Each frame check that mismatches issues one bitslip pulse, up to 4 pulses. If the check after the fourth pulse still mismatches, err is set, done stays low and the sequence returns to idle.
- R5: The sweep steps the tap 0,1,...,31. The frame is held before the sweep and after each step. At the first tap t whose frame differs from the held one, the tap is set to ((t+1)>>1)+2, saturated to 31, and done is set.
- R6: If no frame change is seen at any of the 32 taps, err is set and the tap stays at 31.
- R7: A word-alignment failure leaves the tap output at its value from before the start request.
- R8: The bitslip output is high for exactly one cycle per pulse.
- R9: A start request while busy has no effect. done and err stay as they are until the next accepted start, which clears both.
- R10: The status output is {lock, frame[3:0]}: bit 4 is lock and bits 3:0 are the live frame.
- R11: After every bitslip pulse or tap change, at least SETTLE_CYC cycles (default 16) pass before the frame is sampled again.
- R12: done and err are never high together, and neither is high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle |
| lock_i | input | 1 | Clock generator lock indication |
| frame_i | input | 4 | Captured frame nibble |
| cg_rst_o | output | 1 | Clock generator reset |
| slip_o | output | 1 | Bitslip pulse |
| tap_o | output | 5 | Input delay tap |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Alignment completed |
| err_o | output | 1 | Alignment failed |
| status_o | output | 5 | {lock, frame} status word |

## Verification
The assertions check, on every cycle, that the bitslip pulse is a single cycle wide and that the clock-generator reset and bitslip appear only while busy. They also check that the tap stays still in idle, that a completed sweep never gives a tap below 2, and that the result flags exclude each other and busy. Only the bench scenarios can show the values themselves: the number of bitslips needed to rotate a given frame into the pattern, the final tap for a given edge position, the failure after four slips or a sweep with no edge, the wait for lock, and the settle spacing between pulses.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [2:0] {
    FA_IDLE,
    FA_CGRST,
    FA_LOCK,
    FA_ASETTLE,
    FA_ACHECK,
    FA_SLIP,
    FA_SSETTLE,
    FA_SCHECK
  } fa_state_e;
endpackage

// File: rtl/fa_settle_timer.sv
module fa_settle_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fa_tap_calc.sv
module fa_tap_calc #(
  parameter int unsigned TAP_W = 5
) (
  input  logic [TAP_W-1:0] edge_tap_i,
  output logic [TAP_W-1:0] final_tap_o
);
  localparam logic [TAP_W:0] TAP_LIM = (TAP_W+1)'((1 << TAP_W) - 1);

  logic [TAP_W:0] half;
  logic [TAP_W:0] sum;

  always_comb begin
    half = ({1'b0, edge_tap_i} + (TAP_W+1)'(1)) >> 1;
    sum  = half + (TAP_W+1)'(2);
    final_tap_o = (sum > TAP_LIM) ? TAP_LIM[TAP_W-1:0] : sum[TAP_W-1:0];
  end
endmodule

// File: rtl/frame_align_ctrl.sv
module frame_align_ctrl #(
  parameter int unsigned TAP_W      = 5,
  parameter int unsigned FRAME_W    = 4,
  parameter int unsigned PATTERN    = 12,
  parameter int unsigned MAX_SLIPS  = 4,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned RST_CYC    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               lock_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               cg_rst_o,
  output logic               slip_o,
  output logic [TAP_W-1:0]   tap_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [FRAME_W:0]   status_o
);
  import fa_pkg::*;

  localparam int unsigned TMR_MAX = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int unsigned CNT_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned SLIP_W  = $clog2(MAX_SLIPS + 1);
  localparam logic [TAP_W-1:0]   TAP_LAST = TAP_W'((1 << TAP_W) - 1);
  localparam logic [FRAME_W-1:0] PAT      = PATTERN[FRAME_W-1:0];
  localparam logic [SLIP_W-1:0]  SLIP_LIM = SLIP_W'(MAX_SLIPS);

  fa_state_e          state_q, state_d;
  logic [TAP_W-1:0]   tap_q, tap_d;
  logic [FRAME_W-1:0] held_q, held_d;
  logic [SLIP_W-1:0]  slips_q, slips_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_zero;
  logic [TAP_W-1:0]   final_tap;

  fa_settle_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  fa_tap_calc #(.TAP_W(TAP_W)) calc_i (
    .edge_tap_i  (tap_q),
    .final_tap_o (final_tap)
  );

  always_comb begin
    state_d  = state_q;
    tap_d    = tap_q;
    held_d   = held_q;
    slips_d  = slips_q;
    done_d   = done_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(SETTLE_CYC);
    case (state_q)
      FA_IDLE: begin
        if (start_i) begin
          done_d   = 1'b0;
          err_d    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RST_CYC);
          state_d  = FA_CGRST;
        end
      end
      FA_CGRST: begin
        if (tmr_zero) state_d = FA_LOCK;
      end
      FA_LOCK: begin
        if (lock_i) begin
          slips_d  = '0;
          tmr_load = 1'b1;
          state_d  = FA_ASETTLE;
        end
      end
      FA_ASETTLE: begin
        if (tmr_zero) state_d = FA_ACHECK;
      end
      FA_ACHECK: begin
        if (frame_i == PAT) begin
          held_d   = frame_i;
          tap_d    = '0;
          tmr_load = 1'b1;
          state_d  = FA_SSETTLE;
        end else if (slips_q == SLIP_LIM) begin
          err_d   = 1'b1;
          state_d = FA_IDLE;
        end else begin
          state_d = FA_SLIP;
        end
      end
      FA_SLIP: begin
        slips_d  = slips_q + SLIP_W'(1);
        tmr_load = 1'b1;
        state_d  = FA_ASETTLE;
      end
      FA_SSETTLE: begin
        if (tmr_zero) state_d = FA_SCHECK;
      end
      FA_SCHECK: begin
        if (frame_i != held_q) begin
          tap_d   = final_tap;
          done_d  = 1'b1;
          state_d = FA_IDLE;
        end else if (tap_q == TAP_LAST) begin
          err_d   = 1'b1;
          state_d = FA_IDLE;
        end else begin
          tap_d    = tap_q + TAP_W'(1);
          held_d   = frame_i;
          tmr_load = 1'b1;
          state_d  = FA_SSETTLE;
        end
      end
      default: state_d = FA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FA_IDLE;
      tap_q   <= '0;
      held_q  <= '0;
      slips_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      held_q  <= held_d;
      slips_q <= slips_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign cg_rst_o = (state_q == FA_CGRST);
  assign slip_o   = (state_q == FA_SLIP);
  assign busy_o   = (state_q != FA_IDLE);
  assign tap_o    = tap_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign status_o = {lock_i, frame_i};
endmodule

// File: rtl/frame_align_ctrl_chk.sv
module frame_align_ctrl_chk #(
  parameter int unsigned TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             slip_o,
  input logic             cg_rst_o,
  input logic [TAP_W-1:0] tap_o
);
  assert_slip_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |=> !slip_o);

  assert_cgrst_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cg_rst_o |-> (busy_o && !slip_o));

  assert_slip_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |-> busy_o);

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o) && !(busy_o && (done_o || err_o)));

  assert_tap_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(tap_o));

  assert_tap_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (tap_o >= TAP_W'(2)));
endmodule

bind frame_align_ctrl frame_align_ctrl_chk #(.TAP_W(TAP_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .slip_o   (slip_o),
  .cg_rst_o (cg_rst_o),
  .tap_o    (tap_o)
);

// File: tb/frame_align_ctrl_tb_top.sv
module frame_align_ctrl_tb_top;
  localparam int SETTLE = 16;

  typedef struct packed {
    logic [3:0] init;
    logic [5:0] edge_at;
    logic       exp_err;
    logic [4:0] exp_tap;
    logic [2:0] exp_slips;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'hC, 6'd1,  1'b0, 5'd3,  3'd0},
    '{4'h6, 6'd10, 1'b0, 5'd7,  3'd1},
    '{4'h9, 6'd31, 1'b0, 5'd18, 3'd3},
    '{4'h3, 6'd20, 1'b0, 5'd12, 3'd2},
    '{4'hF, 6'd32, 1'b1, 5'd12, 3'd4},
    '{4'hC, 6'd32, 1'b1, 5'd31, 3'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       lock = 1'b0;
  logic [3:0] frame;
  logic       cg_rst, slip, busy, done, err;
  logic [4:0] tap;
  logic [4:0] status;

  logic [3:0] init_word = 4'hC;
  logic [5:0] edge_at = 6'd40;
  logic       cnt_clr = 1'b0;
  int         lock_lat = 6;
  int         lcnt = 0;
  int         nslip = 0;
  int         ncgr = 0;
  int         gap = 0;
  int         gap_viol = 0;
  logic       have_slip = 1'b0;
  logic       cg_prev = 1'b0;
  int         errors = 0;
  int         checks = 0;

  always #4 clk = ~clk;

  function automatic logic [3:0] rotl(input logic [3:0] w, input int k);
    logic [3:0] r;
    r = w;
    for (int i = 0; i < (k % 4); i++) r = {r[2:0], r[3]};
    return r;
  endfunction

  assign frame = rotl(init_word, nslip) ^ {3'b000, ({1'b0, tap} >= edge_at)};

  always @(posedge clk) begin
    if (cg_rst) begin
      lock <= 1'b0;
      lcnt <= 0;
    end else if (!lock) begin
      if (lcnt >= lock_lat) lock <= 1'b1;
      else lcnt <= lcnt + 1;
    end
    cg_prev <= cg_rst;
    if (cnt_clr) begin
      nslip <= 0; ncgr <= 0; gap <= 0; gap_viol <= 0; have_slip <= 1'b0;
    end else begin
      if (cg_rst && !cg_prev) ncgr <= ncgr + 1;
      if (slip) begin
        nslip <= nslip + 1;
        if (have_slip && gap < SETTLE) gap_viol <= gap_viol + 1;
        gap <= 0;
        have_slip <= 1'b1;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  frame_align_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lock_i(lock), .frame_i(frame),
    .cg_rst_o(cg_rst), .slip_o(slip), .tap_o(tap), .busy_o(busy),
    .done_o(done), .err_o(err), .status_o(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [3:0] w, input logic [5:0] e);
    @(negedge clk);
    init_word = w; edge_at = e; cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R9 busy after start", busy, 1);
    check("R9 flags cleared on start", done | err, 0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R2 sequence finishes", busy, 0);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done/err", done | err, 0);
    check("R1 tap", tap, 0);
    check("R1 slip/cgrst", slip | cg_rst, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 status", status, {lock, frame});

    for (int i = 0; i < 6; i++) begin
      kick(VECS[i].init, VECS[i].edge_at);
      wait_idle();
      check("R5 R6 R7 tap", tap, VECS[i].exp_tap);
      check("R4 R6 err", err, VECS[i].exp_err);
      check("R5 done", done, !VECS[i].exp_err);
      check("R3 R4 slip count", nslip, VECS[i].exp_slips);
      check("R11 settle spacing", gap_viol, 0);
      check("R2 one clock reset", ncgr, 1);
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 tap after reset", tap, 0);
    lock_lat = 300;
    kick(4'h6, 6'd4);
    repeat (100) @(negedge clk);
    check("R2 waiting for lock busy", busy, 1);
    check("R2 no slip before lock", nslip, 0);
    check("R2 tap held before lock", tap, 0);
    check("R10 status lock bit", status[4], 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check("R9 start while busy ignored", ncgr, 1);
    check("R5 tap after delayed lock", tap, 4);
    check("R3 one slip", nslip, 1);
    repeat (50) @(negedge clk);
    check("R9 done held", done, 1);
    check("R9 tap held", tap, 4);
    check("R10 status lock bit high", status, {1'b1, frame});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule